// File: doc/BRIEF.md
# Register Alias Table Renamer

This block maps the register names used by a single instruction stream onto a larger pool of physical registers, one instruction per cycle. For every accepted instruction it looks up where the current values of its two source registers live, and, when the instruction writes a register, hands out a fresh physical tag and points the destination's table entry at it. Because every write gets its own physical register, two writes to the same name, or a write that follows a read of that name, no longer conflict. A reader that follows a writer still receives the writer's tag, so true data dependencies are kept.

The table has one entry per architectural register. After reset, architectural index a points to physical tag a+1, so tags 1 to 16 are in use and tag 0 is never produced as a mapping. New tags are issued from a counter that starts at 17 and only counts up. When the last tag has been issued, the block refuses further instructions until it is reset. The previous mapping of the destination is emitted next to the new tag, so that a later stage can release it once the instruction retires.

Top module: `rat_renamer`

## Requirements
- R1: After reset, a lookup of architectural index a (0 to 15) returns physical tag a+1 on both source outputs, and pool_full is low.
- R2: An instruction accepted at a rising edge (in_valid and in_ready both high) appears on the outputs, with out_valid high, right after the next rising edge; out_valid is low in every cycle that follows an edge without an accept.
- R3: Each source tag output equals the table entry of its architectural index at the time the instruction is accepted.
- R4: Sources are read before the same instruction's destination update, so a source equal to the destination receives the old mapping.
- R5: The first destination tag issued after reset is 17, and each further instruction with in_dst_en high receives the previous tag plus one.
- R6: After an instruction with in_dst_en high is accepted, later lookups of its destination index return the tag it received.
- R7: out_old_tag carries the table entry of the destination index as it was just before the update.
- R8: An instruction with in_dst_en low allocates nothing, leaves the table unchanged, and drives out_new_tag and out_old_tag to 0 with out_dst_en low.
- R9: Once tag 63 has been issued, pool_full goes high and in_ready goes low, and both stay so until reset.
- R10: Input values presented while in_valid is low leave the table and the allocator unchanged and produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The block can accept an instruction |
| in_src_a | input | 4 | First source architectural index |
| in_src_b | input | 4 | Second source architectural index |
| in_dst | input | 4 | Destination architectural index |
| in_dst_en | input | 1 | The instruction writes a register |
| out_valid | output | 1 | Renamed result is present |
| out_tag_a | output | 6 | Physical tag of the first source |
| out_tag_b | output | 6 | Physical tag of the second source |
| out_new_tag | output | 6 | Freshly allocated destination tag |
| out_old_tag | output | 6 | Destination mapping replaced by this instruction |
| out_dst_en | output | 1 | The renamed instruction writes a register |
| pool_full | output | 1 | All tags have been issued |

## Verification
The hardest state to reach is the exhausted pool, since it only appears after every one of the 47 spare tags has been issued and nothing returns them. The bench walks there with a long mixed stream of writers and non-writers whose indices step through all sixteen registers, re-checking each source, old and new tag against a model table along the way, then holds in_valid high against the closed input and confirms that nothing leaks through. A full 16-by-16 sweep of source pairs, before and after a second reset, confirms the identity mapping.

// File: rtl/rat_renamer.sv
module rat_renamer #(
  parameter int ARCH_REGS = 16,
  parameter int TAG_W     = 6,
  localparam int AW       = $clog2(ARCH_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_src_a,
  input  logic [AW-1:0]    in_src_b,
  input  logic [AW-1:0]    in_dst,
  input  logic             in_dst_en,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag_a,
  output logic [TAG_W-1:0] out_tag_b,
  output logic [TAG_W-1:0] out_new_tag,
  output logic [TAG_W-1:0] out_old_tag,
  output logic             out_dst_en,
  output logic             pool_full
);
  localparam logic [TAG_W-1:0] FIRST_TAG = TAG_W'(ARCH_REGS + 1);
  localparam logic [TAG_W-1:0] LAST_TAG  = {TAG_W{1'b1}};

  logic [TAG_W-1:0] map_q [ARCH_REGS];
  logic [TAG_W-1:0] next_tag_q;
  logic             full_q;

  logic accept, alloc;
  assign in_ready  = !full_q;
  assign pool_full = full_q;
  assign accept    = in_valid && in_ready;
  assign alloc     = accept && in_dst_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= TAG_W'(i + 1);
    end else if (alloc) begin
      map_q[in_dst] <= next_tag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_tag_q <= FIRST_TAG;
      full_q     <= 1'b0;
    end else if (alloc) begin
      if (next_tag_q == LAST_TAG) full_q <= 1'b1;
      else next_tag_q <= next_tag_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_tag_a   <= '0;
      out_tag_b   <= '0;
      out_new_tag <= '0;
      out_old_tag <= '0;
      out_dst_en  <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_tag_a   <= map_q[in_src_a];
        out_tag_b   <= map_q[in_src_b];
        out_dst_en  <= in_dst_en;
        out_new_tag <= in_dst_en ? next_tag_q : '0;
        out_old_tag <= in_dst_en ? map_q[in_dst] : '0;
      end
    end
  end
endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk #(
  parameter int ARCH_REGS = 16,
  parameter int TAG_W     = 6,
  localparam int AW       = $clog2(ARCH_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [TAG_W-1:0] out_new_tag,
  input logic [TAG_W-1:0] out_old_tag,
  input logic             out_dst_en,
  input logic             pool_full
);
  logic [TAG_W-1:0] last_new;
  always_ff @(posedge clk) begin
    if (!rst_n) last_new <= TAG_W'(ARCH_REGS);
    else if (out_valid && out_dst_en) last_new <= out_new_tag;
  end

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R2
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid); // R10
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dst_en) |-> (out_new_tag == last_new + 1'b1)); // R5
  AST_NO_DST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dst_en) |-> (out_new_tag == '0 && out_old_tag == '0)); // R8
  AST_FULL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> !in_ready); // R9
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |=> pool_full); // R9
endmodule

bind rat_renamer rat_renamer_chk #(.ARCH_REGS(ARCH_REGS), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_new_tag(out_new_tag), .out_old_tag(out_old_tag),
  .out_dst_en(out_dst_en), .pool_full(pool_full)
);

// File: tb/rat_renamer_tb.sv
`timescale 1ns/1ps
module rat_renamer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic in_dst_en = 1'b0;
  logic out_valid, out_dst_en, pool_full;
  logic [5:0] out_tag_a, out_tag_b, out_new_tag, out_old_tag;

  always #4 clk = ~clk;

  rat_renamer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_dst_en(in_dst_en),
    .out_valid(out_valid), .out_tag_a(out_tag_a), .out_tag_b(out_tag_b),
    .out_new_tag(out_new_tag), .out_old_tag(out_old_tag), .out_dst_en(out_dst_en),
    .pool_full(pool_full)
  );

  int checks = 0, errors = 0;
  int model [16];
  int nxt;
  bit done = 1'b0;

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = i + 1;
    nxt = 17;
  endtask

  task automatic issue(input int a, input int b, input int d, input bit en);
    int ea, eb, eo, en_tag;
    ea = model[a]; eb = model[b];
    eo = en ? model[d] : 0;
    en_tag = en ? nxt : 0;
    in_src_a = 4'(a); in_src_b = 4'(b); in_dst = 4'(d); in_dst_en = en;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid, 1, "R2");
    check(out_tag_a, ea, (a == d && en) ? "R4" : "R3");
    check(out_tag_b, eb, (b == d && en) ? "R4" : "R6");
    check(out_dst_en, en, "R8");
    check(out_new_tag, en_tag, en ? "R5" : "R8");
    check(out_old_tag, eo, en ? "R7" : "R8");
    if (en) begin
      model[d] = nxt;
      nxt++;
    end
  endtask

  task automatic identity_sweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        in_src_a = 4'(a); in_src_b = 4'(b); in_dst = 4'(b); in_dst_en = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_tag_a, a + 1, "R1");
        check(out_tag_b, b + 1, "R1");
      end
  endtask

  initial begin
    do_reset();
    check(pool_full, 0, "R1");
    check(in_ready, 1, "R1");
    check(out_valid, 0, "R2");
    identity_sweep();

    // R10: inputs moving with in_valid low change nothing
    in_valid = 1'b0; in_dst = 4'd5; in_dst_en = 1'b1;
    @(negedge clk);
    check(out_valid, 0, "R10");
    @(negedge clk);
    check(out_valid, 0, "R2");
    issue(5, 5, 0, 1'b0);
    check(out_tag_a, 6, "R10");

    // mixed stream until the pool is exhausted
    for (int i = 0; nxt <= 63; i++) begin
      int d, a, b;
      bit en;
      d = (i * 5 + 3) % 16;
      a = (i * 7) % 16;
      b = (i % 3 == 0) ? d : (i * 11 + 1) % 16;
      en = (i % 4 != 2);
      issue(a, b, d, en);
      if (nxt <= 63) check(pool_full, 0, "R9");
    end
    check(pool_full, 1, "R9");
    check(in_ready, 0, "R9");
    in_valid = 1'b1; in_dst_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid, 0, "R9");
      check(pool_full, 1, "R9");
    end
    in_valid = 1'b0;

    do_reset();
    check(pool_full, 0, "R9");
    identity_sweep();
    issue(2, 2, 2, 1'b1);
    check(out_new_tag, 17, "R5");
    check(out_old_tag, 3, "R7");
    issue(2, 0, 0, 1'b0);
    check(out_tag_a, 17, "R6");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule